// File: doc/BRIEF.md
# Charge Pump Speed-Up Controller

This block drives the mode and enable lines for the charge pumps of a frequency synthesizer. A host loads programming words over a serial bus; the block sees each completed word as a single-cycle load pulse. The pulse carries a two-bit word kind and the word contents. A separate strobe line closes each transfer. When a strobe pulse comes straight after a main-divider word, the main-loop pumps run in speed-up mode for as long as the strobe stays high. A wide strobe therefore gives a long boost, which helps the loop filter slew across a large frequency step.

Two bits of the auxiliary-control word change this timing. One holds speed-up on without any strobe. The other blocks speed-up completely and wins over the first. A gain field in the control word sets the two-bit current-gain code that both loops use. The upper bit of that field also switches off the integral-path pump of the main loop. The auxiliary loop has no speed-up path, so the block gives it only the gain code.

Word kinds: 0 = main-divider word, 1 = reference word, 2 = control word, 3 = auxiliary-control word. All inputs are synchronous to `clk`.

Top module: `cp_speedup_ctrl`

## Requirements
- R1: While reset is active and after it is released, `spu_o` is 0, `pp_en_o` and `pi_en_o` are 1 and `gain_o` is 0.
- R2: If the last word loaded had kind 0, then on the first clock edge that samples `strobe` high, `spu_o` goes to 1 and stays 1 while `strobe` stays high.
- R3: On the first clock edge that samples `strobe` low again, `spu_o` returns to 0, unless the continuous bit is set.
- R4: A strobe pulse that follows a word of kind 1, 2 or 3 does not raise `spu_o`.
- R5: Each kind-0 word arms only one strobe pulse. A second pulse with no new kind-0 word in between does not raise `spu_o`.
- R6: A kind-3 word with bit 15 set holds `spu_o` at 1 from the next clock onward, whatever `strobe` does, until a later kind-3 word clears that bit.
- R7: A kind-3 word with bit 16 set forces `spu_o` to 0 from the next clock onward, even when bit 15 is also set or a strobe pulse is running.
- R8: `gain_o` takes bits [5:4] of each kind-2 word and keeps that value through loads of any other kind.
- R9: `pi_en_o` is the inverse of `gain_o[1]`. `pp_en_o` stays 1 at all times.
- R10: When `ld_vld` is 0, `ld_kind` and `ld_data` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ld_vld | input | 1 | One-cycle pulse marking a completed word load |
| ld_kind | input | 2 | Kind of the loaded word (0 main divider, 1 reference, 2 control, 3 auxiliary control) |
| ld_data | input | WORD_W | Contents of the loaded word |
| strobe | input | 1 | Transfer strobe line |
| spu_o | output | 1 | Speed-up flag for the main-loop pumps |
| pp_en_o | output | 1 | Proportional-path main pump enable |
| pi_en_o | output | 1 | Integral-path main pump enable |
| gain_o | output | 2 | Current-gain code shared by both loops |

## Verification
Strobe pulses are run after each of the four word kinds. This shows whether arming depends on the kind-0 word alone. A second pulse with no new word in between shows whether the arming is used up after one pulse. A kind-3 word arrives partway through a running pulse, first with the disable bit and then without it. This separates the force-off path from the pulse state that it masks. Garbage driven on the load lines while `ld_vld` is 0 shows that the valid qualifier is honoured. Every clock cycle is also compared against a behavioural model of the arming and pulse rules.

// File: rtl/cpsu_pkg.sv
package cpsu_pkg;

  typedef enum logic [1:0] {
    WK_MAIN = 2'd0,
    WK_REF  = 2'd1,
    WK_CTRL = 2'd2,
    WK_AUX  = 2'd3
  } word_kind_e;

  localparam int GAIN_W = 2;

endpackage

// File: rtl/cpsu_word_regs.sv
module cpsu_word_regs
  import cpsu_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int CONT_POS = 15,
  parameter int DIS_POS  = 16,
  parameter int GAIN_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_vld_i,
  input  logic [1:0]        ld_kind_i,
  input  logic [WORD_W-1:0] ld_data_i,
  input  logic              rise_i,
  output logic              armed_o,
  output logic              cont_o,
  output logic              dis_o,
  output logic [GAIN_W-1:0] gain_o
);

  word_kind_e        kind;
  logic              armed_q, armed_n;
  logic              cont_q, cont_n;
  logic              dis_q, dis_n;
  logic [GAIN_W-1:0] gain_q, gain_n;
  logic              upd_en;
  logic              unused_bits;

  assign kind        = word_kind_e'(ld_kind_i);
  assign upd_en      = ld_vld_i | rise_i;
  assign unused_bits = ^ld_data_i;

  // next-state: a strobe rise consumes the arming, a new load overrides it
  always_comb begin
    armed_n = armed_q;
    cont_n  = cont_q;
    dis_n   = dis_q;
    gain_n  = gain_q;
    if (rise_i) begin
      armed_n = 1'b0;
    end
    if (ld_vld_i) begin
      armed_n = (kind == WK_MAIN);
      case (kind)
        WK_CTRL: gain_n = ld_data_i[GAIN_LSB +: GAIN_W];
        WK_AUX: begin
          cont_n = ld_data_i[CONT_POS];
          dis_n  = ld_data_i[DIS_POS];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cont_q  <= 1'b0;
      dis_q   <= 1'b0;
      gain_q  <= '0;
    end else if (upd_en) begin
      armed_q <= armed_n;
      cont_q  <= cont_n;
      dis_q   <= dis_n;
      gain_q  <= gain_n;
    end
  end

  assign armed_o = armed_q;
  assign cont_o  = cont_q;
  assign dis_o   = dis_q;
  assign gain_o  = gain_q;

endmodule

// File: rtl/cpsu_strobe_track.sv
module cpsu_strobe_track (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic armed_i,
  output logic rise_o,
  output logic act_o
);

  logic strb_q;
  logic act_q, act_n;
  logic fall;
  logic act_en;

  assign rise_o = strobe_i & ~strb_q;
  assign fall   = ~strobe_i & strb_q;
  assign act_en = rise_o | fall;

  always_comb begin
    act_n = act_q;
    if (fall) begin
      act_n = 1'b0;
    end else if (rise_o && armed_i) begin
      act_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
    end else begin
      strb_q <= strobe_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (act_en) begin
      act_q <= act_n;
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/cpsu_pump_map.sv
module cpsu_pump_map
  import cpsu_pkg::*;
(
  input  logic              act_i,
  input  logic              cont_i,
  input  logic              dis_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              spu_o,
  output logic              pp_en_o,
  output logic              pi_en_o
);

  // the disable bit masks both the pulse and the continuous request
  assign spu_o   = ~dis_i & (cont_i | act_i);
  assign pp_en_o = 1'b1;
  assign pi_en_o = ~gain_i[GAIN_W-1];

endmodule

// File: rtl/cp_speedup_ctrl.sv
module cp_speedup_ctrl
  import cpsu_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int CONT_POS = 15,
  parameter int DIS_POS  = 16,
  parameter int GAIN_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_vld,
  input  logic [1:0]        ld_kind,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              strobe,
  output logic              spu_o,
  output logic              pp_en_o,
  output logic              pi_en_o,
  output logic [1:0]        gain_o
);

  logic              rst_meta_n, rst_sync_n;
  logic              armed, cont_q, dis_q, rise, act;
  logic [GAIN_W-1:0] gain_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  cpsu_word_regs #(
    .WORD_W  (WORD_W),
    .CONT_POS(CONT_POS),
    .DIS_POS (DIS_POS),
    .GAIN_LSB(GAIN_LSB)
  ) u_words (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ld_vld_i (ld_vld),
    .ld_kind_i(ld_kind),
    .ld_data_i(ld_data),
    .rise_i   (rise),
    .armed_o  (armed),
    .cont_o   (cont_q),
    .dis_o    (dis_q),
    .gain_o   (gain_q)
  );

  cpsu_strobe_track u_strb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .strobe_i(strobe),
    .armed_i (armed),
    .rise_o  (rise),
    .act_o   (act)
  );

  cpsu_pump_map u_map (
    .act_i  (act),
    .cont_i (cont_q),
    .dis_i  (dis_q),
    .gain_i (gain_q),
    .spu_o  (spu_o),
    .pp_en_o(pp_en_o),
    .pi_en_o(pi_en_o)
  );

  assign gain_o = gain_q;

endmodule

// File: rtl/cpsu_checker.sv
module cpsu_checker #(
  parameter int WORD_W   = 24,
  parameter int CONT_POS = 15,
  parameter int DIS_POS  = 16,
  parameter int GAIN_LSB = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_vld,
  input logic [1:0]        ld_kind,
  input logic [WORD_W-1:0] ld_data,
  input logic              strobe,
  input logic              cont_q,
  input logic              spu_o,
  input logic              pi_en_o,
  input logic [1:0]        gain_o
);

  p_cont_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && ld_kind == 2'd3 && ld_data[CONT_POS] && !ld_data[DIS_POS]) |=> spu_o);

  p_dis_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && ld_kind == 2'd3 && ld_data[DIS_POS]) |=> !spu_o);

  p_fall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && $past(strobe) && !cont_q && !ld_vld) |=> !spu_o);

  p_gain_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && ld_kind != 2'd2) |=> $stable(gain_o));

  p_pi_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld && ld_kind == 2'd2) |=> (pi_en_o == !$past(ld_data[GAIN_LSB+1])));

endmodule

bind cp_speedup_ctrl cpsu_checker #(
  .WORD_W  (WORD_W),
  .CONT_POS(CONT_POS),
  .DIS_POS (DIS_POS),
  .GAIN_LSB(GAIN_LSB)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .ld_vld (ld_vld),
  .ld_kind(ld_kind),
  .ld_data(ld_data),
  .strobe (strobe),
  .cont_q (cont_q),
  .spu_o  (spu_o),
  .pi_en_o(pi_en_o),
  .gain_o (gain_o)
);

// File: tb/sim_cp_speedup_ctrl.sv
`timescale 1ns/1ps
module sim_cp_speedup_ctrl;

  localparam int WORD_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ld_vld = 1'b0;
  logic [1:0]        ld_kind = 2'd0;
  logic [WORD_W-1:0] ld_data = '0;
  logic              strobe = 1'b0;
  logic              spu_o, pp_en_o, pi_en_o;
  logic [1:0]        gain_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int m_gain  = 0;
  bit m_cont  = 0, m_dis = 0, m_act = 0, m_armed = 0, m_strb = 0;

  always #2 clk = ~clk;

  cp_speedup_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ld_vld(ld_vld), .ld_kind(ld_kind),
    .ld_data(ld_data), .strobe(strobe), .spu_o(spu_o), .pp_en_o(pp_en_o),
    .pi_en_o(pi_en_o), .gain_o(gain_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  // reference model of arming, pulse and control-bit rules
  always @(posedge clk) begin
    if (!rst_n) begin
      m_gain = 0; m_cont = 0; m_dis = 0; m_act = 0; m_armed = 0; m_strb = 0;
    end else begin
      bit rise, fall, na, narm;
      rise = strobe && !m_strb;
      fall = !strobe && m_strb;
      na = m_act;
      if (fall) na = 0;
      else if (rise && m_armed) na = 1;
      narm = m_armed;
      if (rise) narm = 0;
      if (ld_vld) begin
        narm = (ld_kind == 2'd0);
        if (ld_kind == 2'd2) m_gain = int'(ld_data[5:4]);
        if (ld_kind == 2'd3) begin
          m_cont = ld_data[15];
          m_dis  = ld_data[16];
        end
      end
      m_act = na; m_armed = narm; m_strb = strobe;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("MODEL spu", int'(spu_o), int'(!m_dis && (m_cont || m_act)));
      chk("MODEL gain", int'(gain_o), m_gain);
      chk("MODEL pi_en", int'(pi_en_o), int'(m_gain < 2));
      chk("MODEL pp_en", int'(pp_en_o), 1);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [1:0] k, input logic [WORD_W-1:0] d);
    @(negedge clk);
    ld_vld = 1'b1; ld_kind = k; ld_data = d;
    @(negedge clk);
    ld_vld = 1'b0; ld_kind = 2'd0; ld_data = '0;
  endtask

  task automatic set_strobe(input logic v);
    strobe = v;
    @(negedge clk);
  endtask

  initial begin
    step(2);
    chk("R1 spu in reset", int'(spu_o), 0);
    chk("R1 pp_en in reset", int'(pp_en_o), 1);
    chk("R1 pi_en in reset", int'(pi_en_o), 1);
    chk("R1 gain in reset", int'(gain_o), 0);
    rst_n = 1'b1;
    step(4);
    chk("R1 spu after release", int'(spu_o), 0);

    // R2 / R3: pulse after a main-divider word
    load(2'd0, 24'h00_1234);
    set_strobe(1'b1);
    chk("R2 spu on strobe high", int'(spu_o), 1);
    step(5);
    chk("R2 spu held while strobe high", int'(spu_o), 1);
    set_strobe(1'b0);
    chk("R3 spu cleared on strobe low", int'(spu_o), 0);

    // R5: second pulse without a new main word
    set_strobe(1'b1);
    chk("R5 second pulse ignored", int'(spu_o), 0);
    set_strobe(1'b0);

    // R4: pulses after other word kinds
    for (int k = 1; k < 4; k++) begin
      load(2'(k), '0);
      set_strobe(1'b1);
      chk($sformatf("R4 no speed-up after kind %0d", k), int'(spu_o), 0);
      set_strobe(1'b0);
    end

    // R8 / R9: gain field and integral pump enable
    load(2'd2, 24'h00_0030);
    chk("R8 gain from control word", int'(gain_o), 3);
    chk("R9 pi_en off with gain bit1", int'(pi_en_o), 0);
    chk("R9 pp_en stays on", int'(pp_en_o), 1);
    load(2'd1, 24'hFF_FFFF);
    chk("R8 gain kept across other word", int'(gain_o), 3);
    load(2'd2, 24'h00_0010);
    chk("R8 gain updated", int'(gain_o), 1);
    chk("R9 pi_en back on", int'(pi_en_o), 1);

    // R6: continuous speed-up
    load(2'd3, 24'h00_8000);
    chk("R6 continuous on without strobe", int'(spu_o), 1);
    set_strobe(1'b1);
    set_strobe(1'b0);
    step(1);
    chk("R6 continuous survives strobe fall", int'(spu_o), 1);

    // R7: disable dominates
    load(2'd3, 24'h01_8000);
    chk("R7 disable beats continuous", int'(spu_o), 0);
    load(2'd0, '0);
    set_strobe(1'b1);
    chk("R7 disable blocks pulse", int'(spu_o), 0);
    set_strobe(1'b0);
    load(2'd3, '0);
    chk("R7 cleared bits idle", int'(spu_o), 0);

    // R7: disable arriving mid-pulse, then lifted while strobe stays high
    load(2'd0, '0);
    set_strobe(1'b1);
    chk("R2 pulse active before disable", int'(spu_o), 1);
    strobe = 1'b1;
    load(2'd3, 24'h01_0000);
    chk("R7 disable masks running pulse", int'(spu_o), 0);
    load(2'd3, '0);
    chk("R7 pulse visible once disable lifted", int'(spu_o), 1);
    set_strobe(1'b0);
    chk("R3 cleared after masked pulse", int'(spu_o), 0);

    // R10: load lines without the valid qualifier
    @(negedge clk);
    ld_kind = 2'd3; ld_data = 24'h00_8000;
    step(2);
    chk("R10 unqualified aux word ignored", int'(spu_o), 0);
    ld_kind = 2'd2; ld_data = 24'h00_0030;
    step(2);
    chk("R10 unqualified control word ignored", int'(gain_o), 1);
    ld_kind = 2'd0; ld_data = '0;
    set_strobe(1'b1);
    chk("R10 unqualified main word does not arm", int'(spu_o), 0);
    set_strobe(1'b0);

    step(3);
    finish_run();
  end

endmodule